// File: doc/BRIEF.md
# I2C Slave Address Qualifier Matcher

This block decides whether an address byte received on an I2C bus selects this slave. It does not use a plain equality test. A qualifier value widens the test in one of two ways. In mask mode, each set qualifier bit makes the matching address bit a don't-care. In range mode, the qualifier is the inclusive upper bound of a window whose lower bound is the programmed slave address. A qualifier of zero gives an exact compare in either mode. Bit 0 of the received byte is the read/write flag, and it never takes part in the compare.

A bit shifter upstream presents the received byte together with a one-cycle valid strobe. The block evaluates the match once per strobe. One clock later it reports the result as a single-cycle registered pulse, next to the latched 7-bit address and read/write flag. Logic that decides whether to acknowledge the byte uses these outputs. A low enable suppresses every match.

Top module: `i2c_addr_qualifier`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `hit_pulse`, `hit_addr` and `hit_rw` are all 0.
- R2: The compared address is `rx_byte[7:1]`. `rx_byte[0]` is the read/write flag and never changes the match result. It is latched into `hit_rw`.
- R3: When `qual_val` is 0, a match requires `rx_byte[7:1] == slv_addr` exactly. This holds in both modes.
- R4: In mask mode (`qual_range` = 0), a match occurs when every address bit either equals the matching `slv_addr` bit or has its `qual_val` bit set to 1.
- R5: In range mode (`qual_range` = 1) with a nonzero qualifier, a match occurs when `slv_addr <= rx_byte[7:1] <= qual_val`, as unsigned values. Both bounds are inclusive.
- R6: In range mode with a nonzero `qual_val` below `slv_addr`, the window is empty and no address matches.
- R7: When `slv_enable` is 0 at the strobe, no match is reported, whatever the other inputs are.
- R8: `hit_pulse` is high for exactly the one cycle after a clock edge on which `rx_valid` was high and the address matched. It is never high after an edge without a strobe.
- R9: On every strobe, matched or not, `hit_addr` and `hit_rw` take the received address and read/write flag one cycle later. Between strobes they hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a received address byte |
| rx_byte | input | ADDR_W+1 | Received byte; address in the upper bits, read/write flag in bit 0 |
| slv_enable | input | 1 | Enables matching |
| slv_addr | input | ADDR_W | Programmed slave address (lower bound in range mode) |
| qual_val | input | ADDR_W | Qualifier: don't-care mask or inclusive upper bound |
| qual_range | input | 1 | Qualifier mode: 0 mask, 1 range |
| hit_pulse | output | 1 | Registered single-cycle match pulse |
| hit_addr | output | ADDR_W | Latched received address |
| hit_rw | output | 1 | Latched read/write flag |

## Verification
The bench builds the block with the default 7-bit address width. At that width the whole address space of 128 values fits in a single back-to-back sweep. Every received address is therefore checked against each configuration: an exact compare, a partial mask, a full mask, a window with both edges, an inverted window and a disabled slave. The same sweep drives a strobe on every cycle, so pulses in adjacent cycles and the holding of the latched address during idle gaps are also covered.

// File: rtl/aq_pkg.sv
package aq_pkg;

    typedef enum logic {
        QMODE_MASK  = 1'b0,
        QMODE_RANGE = 1'b1
    } qual_mode_e;

endpackage

// File: rtl/aq_mask_cmp.sv
// Per-bit compare in which a set qualifier bit turns that bit into a don't-care.
module aq_mask_cmp #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [ADDR_W-1:0] ref_addr,
    input  logic [ADDR_W-1:0] care_n,
    output logic              match
);
    logic [ADDR_W-1:0] bit_ok;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign bit_ok[i] = care_n[i] | ~(rx_addr[i] ^ ref_addr[i]);
    end

    assign match = &bit_ok;
endmodule

// File: rtl/aq_range_cmp.sv
// Inclusive window compare; an inverted window (hi < lo) yields no match.
module aq_range_cmp #(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic              match
);
    logic above_lo;
    logic below_hi;

    assign above_lo = (rx_addr >= lo);
    assign below_hi = (rx_addr <= hi);
    assign match    = above_lo & below_hi;
endmodule

// File: rtl/i2c_addr_qualifier.sv
module i2c_addr_qualifier #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [ADDR_W:0]   rx_byte,
    input  logic              slv_enable,
    input  logic [ADDR_W-1:0] slv_addr,
    input  logic [ADDR_W-1:0] qual_val,
    input  logic              qual_range,
    output logic              hit_pulse,
    output logic [ADDR_W-1:0] hit_addr,
    output logic              hit_rw
);
    import aq_pkg::*;

    localparam int BYTE_W = ADDR_W + 1;

    typedef struct packed {
        logic              pulse;
        logic [ADDR_W-1:0] addr;
        logic              rw;
    } state_t;

    state_t state_d, state_q;

    logic [ADDR_W-1:0] rx_addr;
    logic              rx_rw;
    logic              mask_hit;
    logic              range_hit;
    logic              qual_zero;
    qual_mode_e        mode;

    assign rx_addr   = rx_byte[BYTE_W-1:1];
    assign rx_rw     = rx_byte[0];
    assign qual_zero = (qual_val == '0);
    assign mode      = qual_mode_e'(qual_range);

    // With a zero qualifier the mask compare reduces to an exact compare.
    aq_mask_cmp #(.ADDR_W(ADDR_W)) u_mask (
        .rx_addr (rx_addr),
        .ref_addr(slv_addr),
        .care_n  (qual_val),
        .match   (mask_hit)
    );

    aq_range_cmp #(.ADDR_W(ADDR_W)) u_range (
        .rx_addr(rx_addr),
        .lo     (slv_addr),
        .hi     (qual_val),
        .match  (range_hit)
    );

    always_comb begin
        logic hit;
        state_d = state_q;
        state_d.pulse = 1'b0;
        if (qual_zero || mode == QMODE_MASK) begin
            hit = mask_hit;
        end else begin
            hit = range_hit;
        end
        if (rx_valid) begin
            state_d.pulse = hit & slv_enable;
            state_d.addr  = rx_addr;
            state_d.rw    = rx_rw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign hit_pulse = state_q.pulse;
    assign hit_addr  = state_q.addr;
    assign hit_rw    = state_q.rw;
endmodule

// File: rtl/i2c_addr_qualifier_chk.sv
module i2c_addr_qualifier_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic [ADDR_W:0]   rx_byte,
    input logic              slv_enable,
    input logic [ADDR_W-1:0] slv_addr,
    input logic [ADDR_W-1:0] qual_val,
    input logic              qual_range,
    input logic              hit_pulse,
    input logic [ADDR_W-1:0] hit_addr,
    input logic              hit_rw
);
    logic [ADDR_W-1:0] a;
    assign a = rx_byte[ADDR_W:1];

    assert_no_hit_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !slv_enable |=> !hit_pulse);

    assert_no_hit_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !hit_pulse);

    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> ($stable(hit_addr) && $stable(hit_rw)));

    assert_addr_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (hit_addr == $past(a) && hit_rw == $past(rx_byte[0])));

    assert_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && slv_enable && qual_val == '0) |=> (hit_pulse == ($past(a) == $past(slv_addr))));

    assert_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && slv_enable && !qual_range) |=>
        (hit_pulse == ((($past(a) ^ $past(slv_addr)) & ~$past(qual_val)) == '0)));

    assert_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && slv_enable && qual_range && qual_val != '0) |=>
        (hit_pulse == ($past(a) >= $past(slv_addr) && $past(a) <= $past(qual_val))));

    assert_empty_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && qual_range && qual_val != '0 && qual_val < slv_addr) |=> !hit_pulse);
endmodule

bind i2c_addr_qualifier i2c_addr_qualifier_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .slv_enable(slv_enable),
    .slv_addr  (slv_addr),
    .qual_val  (qual_val),
    .qual_range(qual_range),
    .hit_pulse (hit_pulse),
    .hit_addr  (hit_addr),
    .hit_rw    (hit_rw)
);

// File: tb/sim_i2c_addr_qualifier.sv
`timescale 1ns/1ps
module sim_i2c_addr_qualifier;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [AW:0]   rx_byte = '0;
    logic          slv_enable = 1'b0;
    logic [AW-1:0] slv_addr = '0;
    logic [AW-1:0] qual_val = '0;
    logic          qual_range = 1'b0;
    logic          hit_pulse;
    logic [AW-1:0] hit_addr;
    logic          hit_rw;

    always #2.5 clk = ~clk;

    i2c_addr_qualifier #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .slv_enable(slv_enable), .slv_addr(slv_addr), .qual_val(qual_val),
        .qual_range(qual_range), .hit_pulse(hit_pulse), .hit_addr(hit_addr),
        .hit_rw(hit_rw)
    );

    typedef struct {
        logic          pulse;
        logic [AW-1:0] addr;
        logic          rw;
        string         req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   mon_on = 0;
    bit   finished = 0;
    logic strobe_seen = 1'b0;
    logic [AW-1:0] last_addr = '0;
    logic          last_rw = 1'b0;

    // Reference model written from the requirements.
    function automatic logic ref_match(input logic [AW-1:0] a, input logic [AW-1:0] s,
                                       input logic [AW-1:0] q, input logic rng, input logic en);
        if (!en) return 1'b0;                                   // R7
        if (q == '0) return (a == s);                           // R3
        if (!rng) begin                                         // R4
            for (int i = 0; i < AW; i++)
                if (!q[i] && a[i] != s[i]) return 1'b0;
            return 1'b1;
        end
        return (s <= a) && (a <= q);                            // R5, R6 (empty if q < s)
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    // Driver: one strobe per call; consecutive calls give back-to-back strobes.
    task automatic strobe(input logic [AW-1:0] a, input logic rw, input string req);
        exp_t e;
        @(negedge clk);
        rx_byte  = {a, rw};
        rx_valid = 1'b1;
        e.pulse = ref_match(a, slv_addr, qual_val, qual_range, slv_enable);
        e.addr  = a;
        e.rw    = rw;
        e.req   = req;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b0;
        end
    endtask

    task automatic config_set(input logic en, input logic [AW-1:0] s, input logic [AW-1:0] q,
                              input logic rng);
        idle(2);
        slv_enable = en;
        slv_addr   = s;
        qual_val   = q;
        qual_range = rng;
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < (1 << AW); a++) strobe(a[AW-1:0], a[0], req);
        idle(2);
    endtask

    always @(posedge clk) strobe_seen <= rst_n ? rx_valid : 1'b0;

    // Monitor: compares each registered result with the queued expectation.
    always @(negedge clk) begin
        if (mon_on) begin
            if (strobe_seen) begin
                if (exp_q.size() == 0) begin
                    check("R8 unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({e.req, " pulse"}, hit_pulse, e.pulse);
                    check("R9 addr latch", hit_addr, e.addr);
                    check("R2 rw latch", hit_rw, e.rw);
                    last_addr <= e.addr;
                    last_rw   <= e.rw;
                end
            end else begin
                check("R8 no pulse without strobe", hit_pulse, 0);
                check("R9 addr hold", {hit_addr, hit_rw}, {last_addr, last_rw});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pulse in reset", hit_pulse, 0);
        check("R1 addr in reset", {hit_addr, hit_rw}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pulse after reset", hit_pulse, 0);
        check("R1 addr after reset", {hit_addr, hit_rw}, 0);
        mon_on = 1;

        // R3: zero qualifier means exact compare in mask mode and in range mode
        config_set(1, 7'h2A, 7'h00, 0);
        strobe(7'h2A, 0, "R3 exact mask-mode hit");
        strobe(7'h2B, 0, "R3 exact mask-mode miss");
        idle(1);
        config_set(1, 7'h2A, 7'h00, 1);
        strobe(7'h2A, 1, "R3 exact range-mode hit");
        strobe(7'h29, 0, "R3 exact range-mode miss");
        idle(1);
        sweep("R3 sweep");

        // R2: read/write flag ignored for matching
        strobe(7'h2A, 1, "R2 rw=1 still hits");
        strobe(7'h2A, 0, "R2 rw=0 hits");
        idle(1);

        // R4: mask mode with partial and full don't-care masks
        config_set(1, 7'h50, 7'h0F, 0);
        strobe(7'h5F, 1, "R4 masked low bits hit");
        strobe(7'h60, 0, "R4 unmasked bit differs");
        idle(1);
        sweep("R4 sweep partial mask");
        config_set(1, 7'h00, 7'h7F, 0);
        sweep("R4 sweep full mask");

        // R5: inclusive window
        config_set(1, 7'h20, 7'h30, 1);
        strobe(7'h1F, 0, "R5 below low bound");
        strobe(7'h20, 0, "R5 low bound inclusive");
        strobe(7'h30, 1, "R5 high bound inclusive");
        strobe(7'h31, 0, "R5 above high bound");
        idle(3);
        sweep("R5 sweep");
        config_set(1, 7'h33, 7'h33, 1);
        sweep("R5 single-address window");

        // R6: inverted window matches nothing
        config_set(1, 7'h40, 7'h10, 1);
        strobe(7'h40, 0, "R6 inverted at low");
        strobe(7'h10, 0, "R6 inverted at high");
        idle(1);
        sweep("R6 sweep");

        // R7: disabled slave never matches
        config_set(0, 7'h2A, 7'h00, 0);
        strobe(7'h2A, 0, "R7 disabled exact");
        idle(1);
        config_set(0, 7'h00, 7'h7F, 0);
        sweep("R7 sweep disabled");

        idle(4);
        check("R8 queue drained", exp_q.size(), 0);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule